// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block holds the ownership state of a shared security device that up to five software localities reach through one access byte each. A locality asks for the device by writing a command byte into its own access slot. The block grants the device to one locality at a time and returns a status byte per locality. That byte shows whether the reader owns the device, whether ownership was taken away from it, whether it has a request outstanding, and whether some other locality is waiting.

Besides the ordinary request and release flow, a higher-numbered locality can take the device away from a lower-numbered owner. The loser keeps a sticky flag that tells it what happened. When ownership is free, the highest-numbered waiting locality wins. When the device is marked absent, every status byte reads all ones, and a host takes that value as "nothing here".

One write from one locality is accepted per clock. The status bytes are registered, so the effect of a write appears on `status_o` right after the clock edge that accepts it.

Top module: `loc_access_arbiter`

## Requirements
- R1: After reset no locality owns the device, no request is pending and no seized flag is set. Every status byte reads 0x81 (bit7 valid = 1, bit0 establishment = 1, all other bits 0).
- R2: A write with bit1 = 1 from a locality that does not own the device marks a request, and status bit1 of that locality reads 1 while the request is outstanding. If no locality owns the device, the highest-numbered requester is granted at the same edge. It then reads bit5 = 1 and bit7 = 1, and its request flag is cleared.
- R3: Status bit2 of a locality reads 1 exactly when at least one other locality has an outstanding request.
- R4: A write with bit5 = 1 from the owner releases ownership. At the same edge the highest-numbered locality with an outstanding request becomes the owner.
- R5: A bit5 write from a locality that is not the owner, and a bit1 write from the current owner, change no status byte.
- R6: A write with bit3 = 1 from locality L, while the owner is numbered below L, makes L the owner at that edge. The old owner reads bit5 = 0 and bit4 = 1. The same write also grants L when nobody owns the device.
- R7: A bit3 write from a locality numbered at or below the current owner changes no status byte.
- R8: A locality's seized flag (bit4) clears when that locality writes bit4 = 1, or when it is granted ownership again.
- R9: At most one locality reads bit5 = 1 at any time.
- R10: Bit0 always reads 1, bits 6 and 3 always read 0, and writes to bit0 have no effect.
- R11: While `dev_present` is 0, every status byte reads 0xFF. The ownership state is kept, and writes are still applied.
- R12: Within one write the fields act in this order: release (bit5), seized clear (bit4), seize (bit3), request (bit1), then the grant of free ownership to the highest requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_present | input | 1 | 1 when the device is present; 0 forces all status bytes to 0xFF |
| wr_en | input | 1 | Write strobe for one access byte |
| wr_loc | input | 3 | Locality issuing the write; values of N_LOC and above are ignored |
| wr_data | input | 8 | Command byte written by that locality |
| status_o | output | 40 | Registered status bytes, locality k in bits [8k+7:8k] |

## Verification
The assertions assume that `wr_loc` names an existing locality whenever `wr_en` is high. They also assume that the owner-transfer and hold checks see only one write per cycle, which the single write port guarantees. The stimulus draws `wr_loc` only from 0 to 4. Directed sequences walk through request, release, seizure in both directions, flag clearing and absence, and a long random run then mixes every command bit within single writes. The bench model applies the field order of R12 on its own integer owner state.

// File: rtl/loc_acc_pkg.sv
package loc_acc_pkg;
  localparam int B_VALID  = 7;
  localparam int B_ACTIVE = 5;
  localparam int B_SEIZED = 4;
  localparam int B_SEIZE  = 3;
  localparam int B_PEND   = 2;
  localparam int B_REQ    = 1;
  localparam int B_EST    = 0;
  localparam logic [7:0] ABSENT_BYTE = 8'hFF;
  localparam logic [7:0] IDLE_BYTE   = 8'h81;
endpackage

// File: rtl/loc_high_pick.sv
module loc_high_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] pick
);
  // ascending scan: the last hit is the highest index
  always_comb begin
    pick = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/loc_write_decode.sv
module loc_write_decode
  import loc_acc_pkg::*;
#(
  parameter int N  = 5,
  parameter int LW = 3
) (
  input  logic          wr_en,
  input  logic [LW-1:0] wr_loc,
  input  logic [7:0]    wr_data,
  input  logic [N-1:0]  own_q,
  input  logic [N-1:0]  req_q,
  input  logic [N-1:0]  sz_q,
  output logic [N-1:0]  own_n,
  output logic [N-1:0]  req_n,
  output logic [N-1:0]  sz_n
);
  localparam logic [N-1:0] ONE = N'(1);

  logic          wr_ok;
  logic [N-1:0]  sel;
  logic [N-1:0]  low;

  assign wr_ok = wr_en && (int'(wr_loc) < N);
  assign sel   = wr_ok ? (ONE << wr_loc) : '0;
  assign low   = sel - ONE;

  always_comb begin
    own_n = own_q;
    req_n = req_q;
    sz_n  = sz_q;
    if (wr_ok) begin
      if (wr_data[B_ACTIVE] && ((own_q & sel) != '0)) own_n = '0;
      if (wr_data[B_SEIZED]) sz_n = sz_n & ~sel;
      if (wr_data[B_SEIZE] && ((own_n & ~low) == '0)) begin
        sz_n  = (sz_n | own_n) & ~sel;
        own_n = sel;
        req_n = req_n & ~sel;
      end
      if (wr_data[B_REQ] && ((own_n & sel) == '0)) req_n = req_n | sel;
    end
  end
endmodule

// File: rtl/loc_status_fmt.sv
module loc_status_fmt
  import loc_acc_pkg::*;
#(
  parameter int N = 5
) (
  input  logic [N-1:0]   own,
  input  logic [N-1:0]   req,
  input  logic [N-1:0]   sz,
  output logic [N*8-1:0] bytes
);
  localparam logic [N-1:0] ONE = N'(1);

  for (genvar g = 0; g < N; g++) begin : g_loc
    logic [7:0] b;
    always_comb begin
      b           = '0;
      b[B_VALID]  = 1'b1;
      b[B_ACTIVE] = own[g];
      b[B_SEIZED] = sz[g];
      b[B_PEND]   = |(req & ~(ONE << g));
      b[B_REQ]    = req[g];
      b[B_EST]    = 1'b1;
    end
    assign bytes[g*8 +: 8] = b;
  end
endmodule

// File: rtl/loc_access_arbiter.sv
module loc_access_arbiter
  import loc_acc_pkg::*;
#(
  parameter int N_LOC = 5,
  parameter int LOC_W = $clog2(N_LOC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dev_present,
  input  logic               wr_en,
  input  logic [LOC_W-1:0]   wr_loc,
  input  logic [7:0]         wr_data,
  output logic [N_LOC*8-1:0] status_o
);
  localparam logic [N_LOC-1:0] ONE = N_LOC'(1);

  logic [N_LOC-1:0] own_q, req_q, sz_q;
  logic [N_LOC-1:0] own_m, req_m, sz_m;
  logic [N_LOC-1:0] own_d, req_d, sz_d;
  logic [N_LOC-1:0] pick;
  logic [N_LOC*8-1:0] fmt;

  loc_write_decode #(.N(N_LOC), .LW(LOC_W)) u_dec (
    .wr_en(wr_en), .wr_loc(wr_loc), .wr_data(wr_data),
    .own_q(own_q), .req_q(req_q), .sz_q(sz_q),
    .own_n(own_m), .req_n(req_m), .sz_n(sz_m)
  );

  loc_high_pick #(.N(N_LOC)) u_pick (.vec(req_m), .pick(pick));

  always_comb begin
    own_d = own_m;
    req_d = req_m;
    sz_d  = sz_m;
    if (own_m == '0 && req_m != '0) begin
      own_d = pick;
      req_d = req_m & ~pick;
      sz_d  = sz_m & ~pick;
    end
  end

  loc_status_fmt #(.N(N_LOC)) u_fmt (.own(own_d), .req(req_d), .sz(sz_d), .bytes(fmt));

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q    <= '0;
      req_q    <= '0;
      sz_q     <= '0;
      status_o <= {N_LOC{IDLE_BYTE}};
    end else begin
      own_q    <= own_d;
      req_q    <= req_d;
      sz_q     <= sz_d;
      status_o <= dev_present ? fmt : {N_LOC{ABSENT_BYTE}};
    end
  end

  logic seize_hit;
  assign seize_hit = wr_en && (int'(wr_loc) < N_LOC) && wr_data[B_SEIZE] &&
                     (own_q != '0) && (own_q < (ONE << wr_loc));

  // R9
  owner_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(own_q));

  // R6
  seize_take_chk: assert property (@(posedge clk) disable iff (rst)
    seize_hit |=> (own_q == (ONE << $past(wr_loc))));

  // R6
  seize_mark_chk: assert property (@(posedge clk) disable iff (rst)
    seize_hit |=> ((sz_q & $past(own_q)) == $past(own_q)));

  // R5
  owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (own_q != '0 && !(wr_en && (wr_data[B_ACTIVE] || wr_data[B_SEIZE])))
      |=> (own_q == $past(own_q)));

  // R11
  absent_ones_chk: assert property (@(posedge clk) disable iff (rst)
    !dev_present |=> (status_o == {N_LOC{ABSENT_BYTE}}));
endmodule

// File: tb/tb_loc_access_arbiter.sv
`timescale 1ns/1ps
module tb_loc_access_arbiter;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_present = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_loc = '0;
  logic [7:0] wr_data = '0;
  logic [N*8-1:0] status_o;

  int n_tests = 0;
  int n_fail  = 0;
  string tag = "R1";

  int owner = -1;
  bit rq[N];
  bit sz[N];
  bit pres = 1'b1;

  always #2.5 clk = ~clk;

  loc_access_arbiter dut (
    .clk(clk), .rst(rst), .dev_present(dev_present),
    .wr_en(wr_en), .wr_loc(wr_loc), .wr_data(wr_data), .status_o(status_o)
  );

  function automatic logic [N*8-1:0] expected();
    logic [N*8-1:0] v;
    for (int k = 0; k < N; k++) begin
      logic [7:0] b;
      bit others = 0;
      for (int j = 0; j < N; j++) if (j != k && rq[j]) others = 1;
      b = 8'h81;
      b[5] = (owner == k);
      b[4] = sz[k];
      b[2] = others;
      b[1] = rq[k];
      v[k*8 +: 8] = pres ? b : 8'hFF;
    end
    return v;
  endfunction

  task automatic model(bit en, int loc, logic [7:0] d);
    if (en) begin
      if (d[5] && owner == loc) owner = -1;
      if (d[4]) sz[loc] = 0;
      if (d[3] && owner < loc) begin
        if (owner >= 0) sz[owner] = 1;
        owner = loc; rq[loc] = 0; sz[loc] = 0;
      end
      if (d[1] && owner != loc) rq[loc] = 1;
    end
    if (owner < 0) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (rq[i]) begin owner = i; rq[i] = 0; sz[i] = 0; break; end
      end
    end
  endtask

  task automatic step(bit en, int loc, logic [7:0] d, bit p, string t);
    logic [N*8-1:0] e;
    int act;
    @(negedge clk);
    tag = t;
    wr_en = en; wr_loc = 3'(loc); wr_data = d; dev_present = p;
    pres = p;
    model(en, loc, d);
    e = expected();
    @(posedge clk);
    #1;
    n_tests++;
    if (status_o !== e) begin
      n_fail++;
      $display("FAIL %s: status=%h expected=%h", tag, status_o, e);
    end
    if (p) begin
      act = 0;
      for (int k = 0; k < N; k++) act += int'(status_o[k*8+5]);
      n_tests++;
      if (act > 1) begin
        n_fail++;
        $display("FAIL R9: active count=%0d expected<=1", act);
      end
    end
  endtask

  task automatic idle(string t);
    step(0, 0, 8'h00, 1, t);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle("R1");
    idle("R1");
    step(1, 3, 8'h01, 1, "R10");
    step(1, 1, 8'h02, 1, "R2");
    step(1, 2, 8'h02, 1, "R3");
    step(1, 4, 8'h02, 1, "R3");
    step(1, 3, 8'h20, 1, "R5");
    step(1, 1, 8'h02, 1, "R5");
    step(1, 1, 8'h20, 1, "R4");
    step(1, 4, 8'h20, 1, "R4");
    step(1, 0, 8'h08, 1, "R7");
    step(1, 2, 8'h08, 1, "R7");
    step(1, 3, 8'h08, 1, "R6");
    step(1, 4, 8'h08, 1, "R6");
    step(1, 2, 8'h10, 1, "R8");
    step(1, 4, 8'h20, 1, "R4");
    step(1, 3, 8'h02, 1, "R8");
    step(1, 1, 8'h02, 0, "R11");
    step(0, 0, 8'h00, 0, "R11");
    idle("R11");
    step(1, 3, 8'h20, 1, "R4");
    step(1, 0, 8'h08, 1, "R6");
    step(1, 0, 8'h3A, 1, "R12");
    for (int i = 0; i < 400; i++) begin
      step(1, $urandom_range(0, N - 1), 8'($urandom), ($urandom_range(0, 9) != 0), "R12");
    end
    idle("R12");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule